// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This adapter sits between a processor data port and a block of peripheral registers whose native widths vary: 1, 2 or 4 bytes. A parameter table assigns a native width to every aligned 4-byte group of offsets. The processor may issue 8-, 16- or 32-bit requests at any offset. The adapter turns each request into a short run of native-width accesses, issuing one per clock. It splits requests that are wider than the target registers. It widens requests that are narrower than the target register. All byte lanes follow big-endian order: the lowest address maps to the most significant bits.

A narrow write into a wider register becomes a read of the whole native register, a lane merge and a write-back to the same address in the next cycle. A request is refused with an error, and no native access is made, when any of these holds:
- it touches an offset at or above the mapped limit;
- it touches a group whose table width is zero;
- its size code is invalid.

The table holds one 2-bit code per group: 0 means unmapped, 1 byte, 2 halfword, 3 word. The default table maps offsets 0x00-0x0F as byte registers, 0x10-0x1F as halfword registers and 0x20-0x2F as word registers. Every other group is unmapped.

Top module: `mixwidth_adapter`

## Requirements
- R1: Only the low 10 bits of `addr_i` select the register offset. Higher address bits have no effect on the result.
- R2: A request is answered with `err_o` and `done_o` in the cycle after acceptance, with no native access and `rdata_o` zero, in any of these cases: the size code is 3; a touched byte lies at offset 0x200 or above; a touched byte lies in a group whose code is 0.
- R3: A request whose size equals the native width of its group makes exactly one native access, of that width, at the offset aligned down to that width.
- R4: A byte read from a halfword register reads the halfword at the even offset. An even byte offset returns bits [15:8] of that halfword and an odd one returns bits [7:0].
- R5: A byte or halfword read from a word register reads the aligned word and returns the addressed lane in big-endian order. A halfword at word offset 0 is bits [31:16]; otherwise it is bits [15:0].
- R6: A halfword request to byte registers becomes two byte accesses. The lower address supplies bits [15:8] of the result or write data.
- R7: A word request to narrower registers becomes two halfword pieces at offsets +0 and +2, each resolved again by its own group's width. The lower piece carries bits [31:16].
- R8: A narrow write into a wider register first reads the native register. In the next cycle it writes the whole native value back to the same offset, with only the addressed lane replaced.
- R9: The adapter issues at most one native access per cycle and raises `busy_o` from acceptance until done. `done_o` is a single-cycle pulse in the cycle after the last native access. Requests arriving while `busy_o` is high are ignored.
- R10: Request data and read results are right-aligned: a 1-, 2- or 4-byte value occupies the low 8, 16 or 32 bits, and the upper bits of `rdata_o` are zero. Native data on `nat_wdata_o` and `nat_rdata_i` is right-aligned in the same way to the native width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request; accepted when `busy_o` is low |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| addr_i | input | BUS_AW | Byte address; low 10 bits are the offset |
| wdata_i | input | 32 | Write data, right-aligned |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Error qualifier, valid with `done_o` |
| rdata_o | output | 32 | Read result, right-aligned, valid with `done_o` |
| nat_req_o | output | 1 | Native access strobe |
| nat_we_o | output | 1 | Native write enable |
| nat_size_o | output | 2 | Native width code (0 byte, 1 half, 2 word) |
| nat_addr_o | output | ADDR_W | Native offset, aligned to the native width |
| nat_wdata_o | output | 32 | Native write data, right-aligned |
| nat_rdata_i | input | 32 | Native read data, valid in the same cycle as `nat_req_o` |

## Verification
The assertions rely on the peripheral side answering a native read combinationally, in the same cycle as `nat_req_o`. They also rely on the table passed as a parameter containing only codes 0-3. The bench meets both conditions with a behavioural register array that answers reads at once and commits writes on the clock edge. Requests are presented only while the adapter is idle, except for one deliberate request during a busy interval, which checks that such requests are dropped. The expected data, access counts and latencies come from a behavioural model of the splitting and widening rules.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WB   = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

  // Table code: 0 unmapped, 1 byte, 2 half, 3 word -> log2 of bytes
  function automatic logic [1:0] code_to_lg(input logic [1:0] code);
    case (code)
      2'd2:    return 2'd1;
      2'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] lg);
    case (lg)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/mwa_width_lut.sv
module mwa_width_lut #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LIMIT  = 512,
  parameter int unsigned MAP_W  = LIMIT / 2,
  parameter logic [MAP_W-1:0] MAP = MAP_W'(32'h00FF_AA55)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        code_o
);
  localparam int unsigned IW = $clog2(MAP_W);

  logic [IW-1:0] idx;
  logic          unused_lsb;

  assign unused_lsb = ^addr_i[1:0];
  assign idx        = IW'({addr_i[ADDR_W-1:2], 1'b0});

  always_comb begin
    code_o = 2'd0;
    if (addr_i < ADDR_W'(LIMIT)) code_o = MAP[idx +: 2];
  end
endmodule

// File: rtl/mwa_leaf_plan.sv
module mwa_leaf_plan #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] p_i,       // current byte offset
  input  logic [1:0]        n_lg_i,    // request size, log2 bytes
  input  logic [1:0]        k_i,       // byte cursor inside request
  input  logic [1:0]        w_lg_i,    // native width of p_i's group
  output logic [1:0]        s_lg_o,    // piece size
  output logic [ADDR_W-1:0] nat_addr_o,
  output logic [1:0]        nat_sh_o,  // lane shift in native word, bytes
  output logic [1:0]        req_sh_o,  // lane shift in request word, bytes
  output logic              rmw_o,
  output logic              last_o
);
  logic [1:0] wmask, smask, off;
  logic [2:0] nat_t, req_t, k_next;

  always_comb begin
    // widest piece the request hierarchy allows at this cursor
    if (n_lg_i == 2'd2 && k_i == 2'd0 && w_lg_i == 2'd2)              s_lg_o = 2'd2;
    else if (n_lg_i >= 2'd1 && !k_i[0] && w_lg_i >= 2'd1)             s_lg_o = 2'd1;
    else                                                               s_lg_o = 2'd0;

    wmask      = 2'((3'd1 << w_lg_i) - 3'd1);
    smask      = 2'((3'd1 << s_lg_o) - 3'd1);
    off        = p_i[1:0] & wmask & ~smask;
    nat_addr_o = p_i & ~ADDR_W'(wmask);

    nat_t    = (3'd1 << w_lg_i) - {1'b0, off} - (3'd1 << s_lg_o);
    req_t    = (3'd1 << n_lg_i) - {1'b0, k_i} - (3'd1 << s_lg_o);
    nat_sh_o = nat_t[1:0];
    req_sh_o = req_t[1:0];
    rmw_o    = s_lg_o < w_lg_i;

    k_next = {1'b0, k_i} + (3'd1 << s_lg_o);
    last_o = k_next >= (3'd1 << n_lg_i);
  end
endmodule

// File: rtl/mwa_lane.sv
module mwa_lane
  import mwa_pkg::*;
(
  input  logic [DATA_W-1:0] nat_rdata_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        s_lg_i,
  input  logic [1:0]        nat_sh_i,
  input  logic [1:0]        req_sh_i,
  input  logic              merge_i,
  output logic [DATA_W-1:0] rd_piece_o,
  output logic [DATA_W-1:0] nat_wdata_o
);
  logic [DATA_W-1:0] msk, rd_field, wr_field, base, lane_m;

  always_comb begin
    msk         = lane_mask(s_lg_i);
    rd_field    = (nat_rdata_i >> {nat_sh_i, 3'b000}) & msk;
    rd_piece_o  = rd_field << {req_sh_i, 3'b000};
    wr_field    = (wdata_i >> {req_sh_i, 3'b000}) & msk;
    lane_m      = msk << {nat_sh_i, 3'b000};
    base        = merge_i ? hold_i : '0;
    nat_wdata_o = (base & ~lane_m) | (wr_field << {nat_sh_i, 3'b000});
  end
endmodule

// File: rtl/mixwidth_adapter.sv
module mixwidth_adapter
  import mwa_pkg::*;
#(
  parameter int unsigned BUS_AW = 32,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LIMIT  = 512,
  parameter int unsigned MAP_W  = LIMIT / 2,
  parameter logic [MAP_W-1:0] MAP = MAP_W'(32'h00FF_AA55)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic              nat_req_o,
  output logic              nat_we_o,
  output logic [1:0]        nat_size_o,
  output logic [ADDR_W-1:0] nat_addr_o,
  output logic [31:0]       nat_wdata_o,
  input  logic [31:0]       nat_rdata_i
);
  localparam int unsigned NLUT = 3; // first byte, last byte, cursor

  seq_state_e        state_q;
  logic [ADDR_W-1:0] a_q;
  logic [1:0]        n_lg_q, k_q;
  logic              we_q, err_q;
  logic [31:0]       wdata_q, hold_q, acc_q;

  logic [ADDR_W-1:0] a_in, p;
  logic [ADDR_W:0]   last_wide;
  logic              err_in, unused_addr_hi;
  logic [ADDR_W-1:0] lut_addr [NLUT];
  logic [1:0]        lut_code [NLUT];

  logic [1:0]        w_lg, s_lg, nat_sh, req_sh;
  logic [ADDR_W-1:0] plan_addr;
  logic              rmw, last_piece;
  logic [31:0]       rd_piece, lane_wdata;

  assign unused_addr_hi = ^addr_i[BUS_AW-1:ADDR_W];
  assign a_in           = addr_i[ADDR_W-1:0];
  assign last_wide      = {1'b0, a_in} + (ADDR_W+1)'((4'd1 << size_i) - 4'd1);
  assign p              = a_q + ADDR_W'(k_q);

  always_comb begin
    lut_addr[0] = a_in;
    lut_addr[1] = last_wide[ADDR_W-1:0];
    lut_addr[2] = p;
  end

  for (genvar g = 0; g < NLUT; g++) begin : g_lut
    mwa_width_lut #(
      .ADDR_W(ADDR_W), .LIMIT(LIMIT), .MAP_W(MAP_W), .MAP(MAP)
    ) u_lut (
      .addr_i(lut_addr[g]),
      .code_o(lut_code[g])
    );
  end

  // at most two groups are touched by a 1..4 byte request
  assign err_in = (size_i == 2'd3) || (lut_code[0] == 2'd0) || (lut_code[1] == 2'd0)
                || (last_wide >= (ADDR_W+1)'(LIMIT));
  assign w_lg   = code_to_lg(lut_code[2]);

  mwa_leaf_plan #(.ADDR_W(ADDR_W)) u_plan (
    .p_i       (p),
    .n_lg_i    (n_lg_q),
    .k_i       (k_q),
    .w_lg_i    (w_lg),
    .s_lg_o    (s_lg),
    .nat_addr_o(plan_addr),
    .nat_sh_o  (nat_sh),
    .req_sh_o  (req_sh),
    .rmw_o     (rmw),
    .last_o    (last_piece)
  );

  mwa_lane u_lane (
    .nat_rdata_i(nat_rdata_i),
    .hold_i     (hold_q),
    .wdata_i    (wdata_q),
    .s_lg_i     (s_lg),
    .nat_sh_i   (nat_sh),
    .req_sh_i   (req_sh),
    .merge_i    (state_q == ST_WB),
    .rd_piece_o (rd_piece),
    .nat_wdata_o(lane_wdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      n_lg_q  <= '0;
      k_q     <= '0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      wdata_q <= '0;
      hold_q  <= '0;
      acc_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          a_q     <= a_in;
          n_lg_q  <= size_i;
          we_q    <= we_i;
          wdata_q <= wdata_i;
          k_q     <= '0;
          acc_q   <= '0;
          err_q   <= err_in;
          state_q <= err_in ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (!we_q) acc_q <= acc_q | rd_piece;
          if (we_q && rmw) begin
            hold_q  <= nat_rdata_i;
            state_q <= ST_WB;
          end else if (last_piece) begin
            state_q <= ST_FIN;
          end else begin
            k_q <= k_q + 2'((3'd1 << s_lg));
          end
        end
        ST_WB: begin
          if (last_piece) state_q <= ST_FIN;
          else begin
            k_q     <= k_q + 2'((3'd1 << s_lg));
            state_q <= ST_RUN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = state_q == ST_FIN;
  assign err_o       = done_o && err_q;
  assign rdata_o     = acc_q;
  assign nat_req_o   = (state_q == ST_RUN) || (state_q == ST_WB);
  assign nat_we_o    = ((state_q == ST_RUN) && we_q && !rmw) || (state_q == ST_WB);
  assign nat_size_o  = w_lg;
  assign nat_addr_o  = plan_addr;
  assign nat_wdata_o = lane_wdata;

  AST_NAT_IN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nat_req_o |-> (nat_addr_o < ADDR_W'(LIMIT))); // R2
  AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(nat_req_o)); // R2
  AST_NAT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nat_req_o |-> ((nat_addr_o & ((ADDR_W'(1) << nat_size_o) - ADDR_W'(1))) == '0)); // R3
  AST_WB_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) |-> ($past(nat_req_o && !nat_we_o) && $stable(nat_addr_o))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> $past(nat_req_o)); // R9
endmodule

// File: tb/mixwidth_adapter_tb.sv
module mixwidth_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] addr = '0, wdata = '0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        nat_req, nat_we;
  logic [1:0]  nat_size;
  logic [9:0]  nat_addr;
  logic [31:0] nat_wdata, nat_rdata;

  logic [7:0] mem     [0:511];
  logic [7:0] ref_mem [0:511];
  int n_chk = 0, n_err = 0, nat_total = 0;

  always #5 clk = ~clk;

  mixwidth_adapter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .nat_req_o(nat_req), .nat_we_o(nat_we), .nat_size_o(nat_size),
    .nat_addr_o(nat_addr), .nat_wdata_o(nat_wdata), .nat_rdata_i(nat_rdata)
  );

  function automatic logic [7:0] init_byte(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // peripheral model: right-aligned, big-endian (R10)
  always_comb begin
    nat_rdata = '0;
    for (int i = 0; i < 4; i++)
      if (i < (1 << nat_size)) nat_rdata = {nat_rdata[23:0], mem[(int'(nat_addr) + i) % 512]};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_byte(i);
    end else if (nat_req && nat_we) begin
      for (int i = 0; i < 4; i++)
        if (i < (1 << nat_size))
          mem[(int'(nat_addr) + i) % 512] <= 8'(nat_wdata >> (8 * ((1 << nat_size) - 1 - i)));
    end
  end

  always @(posedge clk) if (rst_n && nat_req) nat_total <= nat_total + 1;

  function automatic int wref(int a);
    if (a < 16) return 1;
    if (a < 32) return 2;
    if (a < 48) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] leaf_rd(int a, int n);
    int w, base, off;
    logic [31:0] v;
    w = wref(a); base = a & ~(w - 1); off = (a - base) & ~(n - 1); v = '0;
    for (int i = 0; i < n; i++) v = (v << 8) | 32'(ref_mem[base + off + i]);
    return v;
  endfunction

  function automatic logic [31:0] ref_rd(int a, int n);
    int h, p;
    logic [31:0] v, x;
    if (wref(a) >= n) return leaf_rd(a, n);
    h = n / 2; v = '0;
    for (int j = 0; j < 2; j++) begin
      p = a + j * h;
      if (wref(p) >= h) x = leaf_rd(p, h);
      else x = (leaf_rd(p, 1) << 8) | leaf_rd(p + 1, 1);
      v = (v << (8 * h)) | x;
    end
    return v;
  endfunction

  function automatic int ref_cnt(int a, int n, bit w_en);
    int h, p, c;
    if (wref(a) >= n) return (w_en && wref(a) > n) ? 2 : 1;
    h = n / 2; c = 0;
    for (int j = 0; j < 2; j++) begin
      p = a + j * h;
      if (wref(p) >= h) c += (w_en && wref(p) > h) ? 2 : 1;
      else c += 2;
    end
    return c;
  endfunction

  task automatic leaf_wr(int a, int n, logic [31:0] d);
    int w, base, off;
    w = wref(a); base = a & ~(w - 1); off = (a - base) & ~(n - 1);
    for (int i = 0; i < n; i++) ref_mem[base + off + i] = 8'(d >> (8 * (n - 1 - i)));
  endtask

  task automatic ref_wr(int a, int n, logic [31:0] d);
    int h, p;
    logic [31:0] piece;
    if (wref(a) >= n) begin leaf_wr(a, n, d); return; end
    h = n / 2;
    for (int j = 0; j < 2; j++) begin
      p = a + j * h;
      piece = (d >> (8 * h * (1 - j))) & ((32'd1 << (8 * h)) - 32'd1);
      if (wref(p) >= h) leaf_wr(p, h, piece);
      else begin leaf_wr(p, 1, piece >> 8); leaf_wr(p + 1, 1, piece & 32'hFF); end
    end
  endtask

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_acc(string rq, logic [31:0] a_full, int sz, bit w_en, logic [31:0] d, bit poke);
    int a, n, cnt, cyc, start;
    bit exp_err;
    logic [31:0] exp_rd;
    bit mem_ok;
    a = int'(a_full & 32'h3FF); n = 1 << sz; exp_err = (sz == 3);
    if (!exp_err)
      for (int i = 0; i < n; i++) if (a + i >= 512 || wref(a + i) == 0) exp_err = 1;
    exp_rd = (exp_err || w_en) ? 32'h0 : ref_rd(a, n);
    cnt    = exp_err ? 0 : ref_cnt(a, n, w_en);
    if (!exp_err && w_en) ref_wr(a, n, d);
    start = nat_total;
    req = 1'b1; we = w_en; size = 2'(sz); addr = a_full; wdata = d;
    @(negedge clk); cyc = 1;
    if (poke) begin addr = 32'h0; we = 1'b1; size = 2'd0; wdata = 32'hEE; end
    else req = 1'b0;
    while (!done && cyc < 40) begin @(negedge clk); req = 1'b0; cyc++; end
    chk(done === 1'b1 && cyc == (exp_err ? 1 : cnt + 1), "R9", {rq, " done latency"}, 32'(cyc), 32'(exp_err ? 1 : cnt + 1));
    chk(err === exp_err, rq, "err_o", 32'(err), 32'(exp_err));
    chk(rdata === exp_rd, rq, "rdata_o", rdata, exp_rd);
    chk(nat_total - start == cnt, rq, "native access count", 32'(nat_total - start), 32'(cnt));
    mem_ok = 1;
    for (int i = 0; i < 48; i++) if (mem[i] !== ref_mem[i]) mem_ok = 0;
    chk(mem_ok, rq, "register contents", 32'(mem_ok), 32'd1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9", {rq, " idle after done"}, {30'd0, busy, done}, 32'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) ref_mem[i] = init_byte(i);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && nat_req === 1'b0, "R9", "reset state",
        {29'd0, busy, done, nat_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_acc("R3",  32'h020, 2, 0, 0, 0);          // word on word
    run_acc("R3",  32'h016, 1, 0, 0, 0);          // half on half
    run_acc("R4",  32'h012, 0, 0, 0, 0);          // even byte -> upper
    run_acc("R4",  32'h013, 0, 0, 0, 0);          // odd byte -> lower
    run_acc("R5",  32'h021, 0, 0, 0, 0);
    run_acc("R5",  32'h020, 1, 0, 0, 0);
    run_acc("R5",  32'h022, 1, 0, 0, 0);
    run_acc("R6",  32'h004, 1, 0, 0, 0);
    run_acc("R6",  32'h007, 1, 0, 0, 0);
    run_acc("R7",  32'h008, 2, 0, 0, 0);
    run_acc("R7",  32'h010, 2, 0, 0, 0);
    run_acc("R7",  32'h00E, 2, 0, 0, 0);
    run_acc("R7",  32'h01E, 2, 0, 0, 0);
    run_acc("R8",  32'h013, 0, 1, 32'h0000_005A, 0);
    run_acc("R8",  32'h02A, 0, 1, 32'h0000_00C3, 0);
    run_acc("R8",  32'h026, 1, 1, 32'h0000_BEEF, 0);
    run_acc("R8",  32'h027, 1, 0, 0, 0);
    run_acc("R10", 32'h005, 0, 1, 32'hFFFF_FF77, 0);
    run_acc("R10", 32'h004, 1, 0, 0, 0);
    run_acc("R6",  32'h002, 1, 1, 32'h0000_1234, 0);
    run_acc("R7",  32'h00C, 2, 1, 32'hA1B2_C3D4, 0);
    run_acc("R7",  32'h01E, 2, 1, 32'h5566_7788, 0);
    run_acc("R7",  32'h01C, 2, 0, 0, 0);
    run_acc("R2",  32'h200, 0, 0, 0, 0);
    run_acc("R2",  32'h030, 0, 1, 32'h11, 0);
    run_acc("R2",  32'h02E, 2, 1, 32'hDEAD_BEEF, 0);
    run_acc("R2",  32'h020, 3, 0, 0, 0);
    run_acc("R1",  32'hFFFF_FC21, 0, 0, 0, 0);
    run_acc("R1",  32'h0000_0412, 1, 0, 0, 0);
    run_acc("R1",  32'h0000_0612, 0, 1, 32'h99, 0);
    run_acc("R9",  32'h008, 2, 0, 0, 1);           // request during busy is dropped
    summary();
    $finish;
  end
endmodule